// File: doc/BRIEF.md
# Dual-Mode Programmable Loop Divider with Phase Detector

This block is the digital core of a tuner PLL. It divides a local-oscillator pulse stream by a programmable ratio N and compares the result against a reference tick. The reference tick comes from a crystal tick stream and is divided down to one of twelve loop reference frequencies. The comparison drives a three-state phase output, and an unlock flag watches for missed or extra divided pulses.

The divider has two structures that share a single 12-bit main counter. In swallow mode, a 16/17 dual-modulus prescaler is steered by a 4-bit swallow counter, which gives N = 16·P + S. In direct mode, the oscillator pulses go straight into the main counter. Each oscillator input and the crystal input is modelled as a one-clock enable pulse on the system clock, so one pulse stands for one input cycle. The divisor, band and mode fields are sampled only when a divided cycle ends.

Top module: `lodiv_top`

## Requirements
- R1: With `band_hi_i`=1, the divider counts `lo_hi_i` pulses and always uses swallow mode, whatever `swallow_en_i` is. With `band_hi_i`=0, it counts `lo_lo_i` pulses, and `swallow_en_i` picks swallow mode (1) or direct mode (0).
- R2: In swallow mode, the spacing between `div_o` pulses is 16·P + S oscillator pulses. P is `divisor_i[15:4]` and S is `divisor_i[3:0]`, so the spacing equals `divisor_i`.
- R3: In direct mode, the spacing is `divisor_i[11:0]` oscillator pulses, and `divisor_i[15:12]` has no effect.
- R4: A divisor below the minimum for its mode is replaced by that minimum. The minimum is 272 in swallow mode and 5 in direct mode. `clamp_err_o` shows whether the settings loaded at the last `div_o` were clamped, and it changes only together with a `div_o` pulse.
- R5: Band, mode and divisor are loaded only at the oscillator pulse that ends a divided cycle, so changes made mid-cycle do not shorten or stretch it. After reset, the first selected oscillator pulse produces `div_o` and loads the settings.
- R6: `div_o` and `ref_o` are one clock wide and appear one clock after the input pulse that completes the count.
- R7: The reference spacing is the crystal frequency divided by the selected reference frequency, counted in crystal ticks. `xtal_sel_i`=0 selects a 7.2 MHz crystal and 1 selects 4.5 MHz. `ref_sel_i` codes 0 to 11 select 1, 3, 3.125, 5, 6.25, 9, 10, 12.5, 25, 30, 50 and 100 kHz in that order, and codes 12 to 15 also select 100 kHz. The reference settings are loaded at the end of each reference period.
- R8: The phase output drives high (`pd_oe_o`=1, `pd_val_o`=1) after a divided pulse that is not matched by a reference pulse. It drives low (`pd_oe_o`=1, `pd_val_o`=0) after an unmatched reference pulse. It floats (`pd_oe_o`=0) when the two balance. Pulses that arrive in the same clock leave it unchanged, and it never moves straight from high to low or from low to high.
- R9: At each `ref_o`, `unlock_o` is set if the reference period that just ended held a number of `div_o` pulses other than one. The period before the first `ref_o` is not judged. The flag holds until a `unlock_rd_i` pulse clears it, and a set in the same clock wins over the clear.
- R10: During and right after reset, `div_o`, `ref_o`, `pd_oe_o`, `unlock_o` and `clamp_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_hi_i | input | 1 | High-band oscillator pulse, one per input cycle |
| lo_lo_i | input | 1 | Low-band oscillator pulse, one per input cycle |
| xtal_tick_i | input | 1 | Crystal pulse, one per crystal cycle |
| band_hi_i | input | 1 | Band select: 1 = high band (swallow mode only) |
| swallow_en_i | input | 1 | Low-band mode: 1 = swallow mode, 0 = direct mode |
| divisor_i | input | 16 | Division ratio N |
| xtal_sel_i | input | 1 | Crystal frequency: 0 = 7.2 MHz, 1 = 4.5 MHz |
| ref_sel_i | input | 4 | Reference frequency code |
| unlock_rd_i | input | 1 | Read pulse that clears the unlock flag |
| div_o | output | 1 | Divided output pulse |
| ref_o | output | 1 | Reference pulse |
| pd_oe_o | output | 1 | Phase output drive enable (0 = float) |
| pd_val_o | output | 1 | Phase output level while driven |
| unlock_o | output | 1 | Sticky unlock flag |
| clamp_err_o | output | 1 | Settings loaded at the last divided pulse were clamped |

## Verification
`div_o` and `clamp_err_o` change in the clock edge that takes the closing oscillator pulse. `ref_o` changes in the edge that takes the closing crystal tick. The phase output follows one edge later, and `unlock_o` changes one edge after `ref_o`. The bench samples on the falling edge and counts each input pulse after the edge that consumed it. It records the band, mode and divisor present at each `div_o` edge and compares the next spacing against that record, which holds even when settings change mid-cycle. The phase and unlock checks start only after a settling window that covers the one-edge latency and the pending cycle under the old settings.

// File: rtl/lodiv_pkg.sv
package lodiv_pkg;

  localparam int unsigned MAIN_W     = 12;
  localparam int unsigned SWL_W      = 4;
  localparam int unsigned DIV_W      = MAIN_W + SWL_W;
  localparam int unsigned REF_W      = 13;
  localparam int unsigned RSEL_W     = 4;
  localparam int unsigned REF_CODES  = 12;
  localparam int unsigned SWL_MIN    = 17 * (1 << SWL_W);
  localparam int unsigned DIR_MIN    = 5;

  typedef enum logic {
    MODE_DIRECT  = 1'b0,
    MODE_SWALLOW = 1'b1
  } div_mode_e;

  typedef struct packed {
    logic              use_hi;
    div_mode_e         mode;
    logic [MAIN_W-1:0] main;
    logic [SWL_W-1:0]  swl;
    logic              err;
  } div_cfg_t;

  typedef enum logic [1:0] {
    PD_FLOAT = 2'd0,
    PD_HIGH  = 2'd1,
    PD_LOW   = 2'd2
  } pd_state_e;

  // Crystal ticks per reference period for the 7.2 MHz crystal, ascending frequency.
  function automatic logic [REF_W-1:0] ref_ticks_base(input logic [RSEL_W-1:0] code);
    unique case (code)
      4'd0:    return REF_W'(7200);
      4'd1:    return REF_W'(2400);
      4'd2:    return REF_W'(2304);
      4'd3:    return REF_W'(1440);
      4'd4:    return REF_W'(1152);
      4'd5:    return REF_W'(800);
      4'd6:    return REF_W'(720);
      4'd7:    return REF_W'(576);
      4'd8:    return REF_W'(288);
      4'd9:    return REF_W'(240);
      4'd10:   return REF_W'(144);
      default: return REF_W'(72);
    endcase
  endfunction

endpackage

// File: rtl/lodiv_cfg_decode.sv
module lodiv_cfg_decode
  import lodiv_pkg::*;
#(
  parameter int unsigned MW = MAIN_W,
  parameter int unsigned SW = SWL_W
) (
  input  logic            band_hi_i,
  input  logic            swallow_en_i,
  input  logic [MW+SW-1:0] divisor_i,
  output div_cfg_t        cfg_o
);
  localparam int unsigned DW = MW + SW;

  logic [DW-1:0] n_swl;
  logic [MW-1:0] n_dir;

  always_comb begin
    cfg_o        = '0;
    cfg_o.use_hi = band_hi_i;
    cfg_o.mode   = (band_hi_i || swallow_en_i) ? MODE_SWALLOW : MODE_DIRECT;
    n_swl        = divisor_i;
    n_dir        = divisor_i[MW-1:0];
    if (cfg_o.mode == MODE_SWALLOW) begin
      if (divisor_i < DW'(SWL_MIN)) begin
        n_swl     = DW'(SWL_MIN);
        cfg_o.err = 1'b1;
      end
      cfg_o.main = n_swl[DW-1:SW];
      cfg_o.swl  = n_swl[SW-1:0];
    end else begin
      if (n_dir < MW'(DIR_MIN)) begin
        n_dir     = MW'(DIR_MIN);
        cfg_o.err = 1'b1;
      end
      cfg_o.main = n_dir;
      cfg_o.swl  = '0;
    end
  end

endmodule

// File: rtl/lodiv_main_div.sv
module lodiv_main_div
  import lodiv_pkg::*;
#(
  parameter int unsigned MW = MAIN_W,
  parameter int unsigned SW = SWL_W
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lo_hi_i,
  input  logic     lo_lo_i,
  input  div_cfg_t req_cfg_i,
  output logic     div_o,
  output logic     err_o
);
  localparam int unsigned PW = SW + 1;
  localparam logic [PW-1:0] PRE_LONG  = PW'(1 << SW);        // 17 pulses
  localparam logic [PW-1:0] PRE_SHORT = PW'((1 << SW) - 1);  // 16 pulses

  div_cfg_t      act_q;
  logic          started_q;
  logic [PW-1:0] pre_q;
  logic [SW-1:0] swl_q;
  logic [MW-1:0] main_q;
  logic          div_q, err_q;

  logic lo_sel, lo_pulse, pre_evt, term;

  assign lo_sel   = started_q ? act_q.use_hi : req_cfg_i.use_hi;
  assign lo_pulse = lo_sel ? lo_hi_i : lo_lo_i;
  assign pre_evt  = (act_q.mode == MODE_DIRECT) || (pre_q == '0);
  assign term     = !started_q || (pre_evt && (main_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      started_q <= 1'b0;
      pre_q     <= '0;
      swl_q     <= '0;
      main_q    <= '0;
      div_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      div_q <= 1'b0;
      if (lo_pulse) begin
        if (term) begin
          // end of a divided cycle: take new settings here only
          started_q <= 1'b1;
          act_q     <= req_cfg_i;
          div_q     <= 1'b1;
          err_q     <= req_cfg_i.err;
          main_q    <= req_cfg_i.main - MW'(1);
          swl_q     <= req_cfg_i.swl;
          pre_q     <= (req_cfg_i.swl != '0) ? PRE_LONG : PRE_SHORT;
        end else if (pre_evt) begin
          main_q <= main_q - MW'(1);
          if (act_q.mode == MODE_SWALLOW) begin
            if (swl_q != '0) swl_q <= swl_q - SW'(1);
            pre_q <= (swl_q > SW'(1)) ? PRE_LONG : PRE_SHORT;
          end
        end else begin
          pre_q <= pre_q - PW'(1);
        end
      end
    end
  end

  assign div_o = div_q;
  assign err_o = err_q;

endmodule

// File: rtl/lodiv_ref_div.sv
module lodiv_ref_div
  import lodiv_pkg::*;
#(
  parameter int unsigned RW = REF_W,
  parameter int unsigned CW = RSEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xtal_tick_i,
  input  logic          xtal_sel_i,
  input  logic [CW-1:0] ref_sel_i,
  output logic          ref_o
);
  localparam int unsigned XW = RW + 3;

  logic [CW-1:0] code;
  logic [RW-1:0] base, ticks;
  logic [XW-1:0] scaled;
  logic [RW-1:0] cnt_q;
  logic          started_q, ref_q, term;

  assign code   = (ref_sel_i >= CW'(REF_CODES)) ? CW'(REF_CODES - 1) : ref_sel_i;
  assign base   = ref_ticks_base(code);
  assign scaled = ({3'b000, base} * XW'(5)) >> 3;   // 4.5 / 7.2 = 5 / 8
  assign ticks  = xtal_sel_i ? scaled[RW-1:0] : base;
  assign term   = !started_q || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      ref_q     <= 1'b0;
    end else begin
      ref_q <= 1'b0;
      if (xtal_tick_i) begin
        if (term) begin
          started_q <= 1'b1;
          ref_q     <= 1'b1;
          cnt_q     <= ticks - RW'(1);
        end else begin
          cnt_q <= cnt_q - RW'(1);
        end
      end
    end
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/lodiv_phase_det.sv
module lodiv_phase_det
  import lodiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_p_i,
  input  logic ref_p_i,
  input  logic unlock_rd_i,
  output logic pd_oe_o,
  output logic pd_val_o,
  output logic unlock_o
);
  pd_state_e st_q;
  logic [1:0] dcnt_q;
  logic       seen_q, unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PD_FLOAT;
    end else if (div_p_i && !ref_p_i) begin
      st_q <= (st_q == PD_LOW) ? PD_FLOAT : PD_HIGH;
    end else if (ref_p_i && !div_p_i) begin
      st_q <= (st_q == PD_HIGH) ? PD_FLOAT : PD_LOW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q   <= '0;
      seen_q   <= 1'b0;
      unlock_q <= 1'b0;
    end else if (ref_p_i) begin
      seen_q <= 1'b1;
      dcnt_q <= {1'b0, div_p_i};
      if (seen_q && (dcnt_q != 2'd1)) unlock_q <= 1'b1;
      else if (unlock_rd_i)           unlock_q <= 1'b0;
    end else begin
      if (div_p_i && (dcnt_q != 2'd3)) dcnt_q <= dcnt_q + 2'd1;
      if (unlock_rd_i) unlock_q <= 1'b0;
    end
  end

  assign pd_oe_o  = (st_q != PD_FLOAT);
  assign pd_val_o = (st_q == PD_HIGH);
  assign unlock_o = unlock_q;

endmodule

// File: rtl/lodiv_top.sv
module lodiv_top
  import lodiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_hi_i,
  input  logic              lo_lo_i,
  input  logic              xtal_tick_i,
  input  logic              band_hi_i,
  input  logic              swallow_en_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              xtal_sel_i,
  input  logic [RSEL_W-1:0] ref_sel_i,
  input  logic              unlock_rd_i,
  output logic              div_o,
  output logic              ref_o,
  output logic              pd_oe_o,
  output logic              pd_val_o,
  output logic              unlock_o,
  output logic              clamp_err_o
);
  div_cfg_t req_cfg;

  lodiv_cfg_decode #(.MW(MAIN_W), .SW(SWL_W)) u_dec (
    .band_hi_i    (band_hi_i),
    .swallow_en_i (swallow_en_i),
    .divisor_i    (divisor_i),
    .cfg_o        (req_cfg)
  );

  lodiv_main_div #(.MW(MAIN_W), .SW(SWL_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lo_hi_i   (lo_hi_i),
    .lo_lo_i   (lo_lo_i),
    .req_cfg_i (req_cfg),
    .div_o     (div_o),
    .err_o     (clamp_err_o)
  );

  lodiv_ref_div #(.RW(REF_W), .CW(RSEL_W)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xtal_tick_i (xtal_tick_i),
    .xtal_sel_i  (xtal_sel_i),
    .ref_sel_i   (ref_sel_i),
    .ref_o       (ref_o)
  );

  lodiv_phase_det u_pd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_p_i     (div_o),
    .ref_p_i     (ref_o),
    .unlock_rd_i (unlock_rd_i),
    .pd_oe_o     (pd_oe_o),
    .pd_val_o    (pd_val_o),
    .unlock_o    (unlock_o)
  );

endmodule

// File: rtl/lodiv_checker.sv
module lodiv_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic lo_hi_i,
  input logic lo_lo_i,
  input logic xtal_tick_i,
  input logic unlock_rd_i,
  input logic div_o,
  input logic ref_o,
  input logic pd_oe_o,
  input logic pd_val_o,
  input logic unlock_o,
  input logic clamp_err_o
);

  assert_div_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  assert_ref_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> !ref_o);

  assert_div_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> $past(lo_hi_i || lo_lo_i));

  assert_ref_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> $past(xtal_tick_i));

  assert_err_at_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clamp_err_o) |-> div_o);

  assert_pd_no_hi_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_oe_o && pd_val_o) |=> !(pd_oe_o && !pd_val_o));

  assert_pd_no_lo_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_oe_o && !pd_val_o) |=> !(pd_oe_o && pd_val_o));

  assert_unlock_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_rd_i && !ref_o) |=> !unlock_o);

  assert_unlock_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_o) |-> $past(ref_o));

endmodule

bind lodiv_top lodiv_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lo_hi_i     (lo_hi_i),
  .lo_lo_i     (lo_lo_i),
  .xtal_tick_i (xtal_tick_i),
  .unlock_rd_i (unlock_rd_i),
  .div_o       (div_o),
  .ref_o       (ref_o),
  .pd_oe_o     (pd_oe_o),
  .pd_val_o    (pd_val_o),
  .unlock_o    (unlock_o),
  .clamp_err_o (clamp_err_o)
);

// File: tb/sim_lodiv_top.sv
module sim_lodiv_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lo_hi, lo_lo, xtal, band_hi, sw_en, xsel, urd;
  logic [15:0] divisor;
  logic [3:0]  rsel;
  logic        div_o, ref_o, pd_oe, pd_val, unlock, cerr;

  always #10 clk = ~clk;   // 50 MHz

  lodiv_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .lo_hi_i(lo_hi), .lo_lo_i(lo_lo),
    .xtal_tick_i(xtal), .band_hi_i(band_hi), .swallow_en_i(sw_en),
    .divisor_i(divisor), .xtal_sel_i(xsel), .ref_sel_i(rsel),
    .unlock_rd_i(urd), .div_o(div_o), .ref_o(ref_o), .pd_oe_o(pd_oe),
    .pd_val_o(pd_val), .unlock_o(unlock), .clamp_err_o(cerr)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  longint cnt_hi = 0, cnt_lo = 0, cnt_x = 0;
  int divs = 0, refs = 0, p_lo = 60, p_x = 70;
  bit mid_phase = 0, prev_div = 0, prev_ref = 0;
  bit dv_valid = 0, dv_hi;  longint dv_snap; int dv_exp; string dv_tag;
  bit rf_valid = 0;         longint rf_snap; int rf_exp;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input bit hi, input bit swen, input logic [15:0] d, output bit e);
    int n;
    if (hi || swen) begin n = int'(d);       e = (n < 272); if (e) n = 272; end
    else            begin n = int'(d[11:0]); e = (n < 5);   if (e) n = 5;   end
    return n;
  endfunction

  function automatic int exp_ref(input bit xs, input logic [3:0] code);
    int hz;
    case (code)
      4'd0: hz = 1000;  4'd1: hz = 3000;  4'd2: hz = 3125;  4'd3: hz = 5000;
      4'd4: hz = 6250;  4'd5: hz = 9000;  4'd6: hz = 10000; 4'd7: hz = 12500;
      4'd8: hz = 25000; 4'd9: hz = 30000; 4'd10: hz = 50000; default: hz = 100000;
    endcase
    return (xs ? 4500000 : 7200000) / hz;
  endfunction

  // one clock: sample at falling edge, run monitors
  task automatic tick();
    bit e;
    int n;
    @(negedge clk);
    if (lo_hi) cnt_hi++;
    if (lo_lo) cnt_lo++;
    if (xtal)  cnt_x++;
    if (div_o) begin
      divs++;
      chk(!prev_div, "R6", prev_div, 0);
      if (dv_valid)
        chk(((dv_hi ? cnt_hi : cnt_lo) - dv_snap) == dv_exp, dv_tag,
            (dv_hi ? cnt_hi : cnt_lo) - dv_snap, dv_exp);
      n = exp_n(band_hi, sw_en, divisor, e);
      chk(cerr == e, "R4", cerr, e);
      dv_valid = 1; dv_hi = band_hi; dv_exp = n;
      dv_snap  = band_hi ? cnt_hi : cnt_lo;
      dv_tag   = mid_phase ? "R5" : (band_hi && !sw_en) ? "R1" : (band_hi || sw_en) ? "R2" : "R3";
    end
    if (ref_o) begin
      refs++;
      chk(!prev_ref, "R6", prev_ref, 0);
      if (rf_valid) chk((cnt_x - rf_snap) == rf_exp, "R7", cnt_x - rf_snap, rf_exp);
      rf_valid = 1; rf_snap = cnt_x; rf_exp = exp_ref(xsel, rsel);
    end
    prev_div = div_o;
    prev_ref = ref_o;
  endtask

  task automatic drive_rand();
    lo_hi = ($urandom_range(0, 99) < p_lo);
    lo_lo = ($urandom_range(0, 99) < p_lo);
    xtal  = ($urandom_range(0, 99) < p_x);
  endtask

  task automatic wait_divs(input int k);
    int target = divs + k;
    while (divs < target) begin tick(); drive_rand(); end
  endtask

  task automatic wait_refs(input int k);
    int target = refs + k;
    while (refs < target) begin tick(); drive_rand(); end
  endtask

  task automatic do_reset();
    rst_n = 0; lo_hi = 0; lo_lo = 0; xtal = 0; urd = 0;
    dv_valid = 0; rf_valid = 0; prev_div = 0; prev_ref = 0;
    repeat (3) tick();
    rst_n = 1;
  endtask

  task automatic set_cfg(input bit hi, input bit sw, input logic [15:0] d);
    band_hi = hi; sw_en = sw; divisor = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit nohi, nolo, sawhi, sawlo, bad;
    void'($urandom(32'd1234));
    band_hi = 0; sw_en = 0; divisor = 16'd50; xsel = 0; rsel = 4'd11;
    do_reset();
    tick();
    // R10 reset state
    chk(!div_o && !ref_o && !pd_oe && !unlock && !cerr, "R10",
        {div_o, ref_o, pd_oe, unlock, cerr}, 0);

    // R5 first pulse after reset emits div_o one clock later (R6)
    lo_lo = 1; tick(); lo_lo = 0;
    chk(div_o == 1, "R5", div_o, 1);
    tick();
    chk(div_o == 0, "R6", div_o, 0);

    // R3 direct mode, random ratios, upper bits junk
    for (int k = 0; k < 8; k++) begin
      set_cfg(0, 0, {4'($urandom_range(0, 15)), 12'($urandom_range(5, 400))});
      wait_divs(2);
    end
    set_cfg(0, 0, 16'h0FFF); wait_divs(2);

    // R2 swallow mode on low band, S corners and random
    set_cfg(0, 1, 16'd272); wait_divs(2);
    set_cfg(0, 1, 16'd287); wait_divs(2);
    set_cfg(0, 1, 16'd288); wait_divs(2);
    for (int k = 0; k < 6; k++) begin
      set_cfg(0, 1, 16'($urandom_range(272, 1500)));
      wait_divs(2);
    end

    // R1 high band ignores swallow_en
    for (int k = 0; k < 4; k++) begin
      set_cfg(1, k[0], 16'($urandom_range(272, 1200)));
      wait_divs(2);
    end

    // R4 clamps
    set_cfg(0, 1, 16'd100);   wait_divs(2);
    set_cfg(1, 0, 16'd0);     wait_divs(2);
    set_cfg(0, 0, 16'h0002);  wait_divs(2);
    set_cfg(0, 0, 16'hF003);  wait_divs(2);
    set_cfg(0, 0, 16'd40);    wait_divs(2);

    // R5 settings changed at random points mid-cycle
    mid_phase = 1;
    for (int c = 0; c < 6000; c++) begin
      tick(); drive_rand();
      if ($urandom_range(0, 59) == 0) begin
        if ($urandom_range(0, 1) == 1)
          set_cfg(1'($urandom_range(0, 1)), 1, 16'($urandom_range(272, 400)));
        else
          set_cfg(0, 0, 16'($urandom_range(0, 120)));
      end
    end
    set_cfg(0, 0, 16'd30); wait_divs(2);
    mid_phase = 0;

    // R7 reference selections, settings change mid-period
    p_x = 100;
    xsel = 0; rsel = 4'd11; wait_refs(2);
    xsel = 1; rsel = 4'd11; wait_refs(2);
    xsel = 1; rsel = 4'd2;  wait_refs(2);
    xsel = 0; rsel = 4'd2;  wait_refs(2);
    xsel = 1; rsel = 4'd0;  wait_refs(2);
    xsel = 0; rsel = 4'd8;  wait_refs(2);
    xsel = 1; rsel = 4'd14; wait_refs(2);
    xsel = 0; rsel = 4'd12; wait_refs(2);
    xsel = 0; rsel = 4'd5;  wait_refs(2);

    // R8/R9 matched from reset: pulses coincide, output floats, stays locked
    xsel = 1; rsel = 4'd11; set_cfg(0, 0, 16'd45);
    do_reset();
    bad = 0;
    for (int c = 0; c < 2000; c++) begin
      lo_lo = 1; xtal = 1; lo_hi = 0; tick();
      if (pd_oe || unlock) bad = 1;
    end
    chk(!bad, "R8", bad, 0);
    // R9 missing divided pulses set unlock
    for (int c = 0; c < 200; c++) begin lo_lo = 0; xtal = 1; tick(); end
    chk(unlock == 1, "R9", unlock, 1);
    for (int c = 0; c < 300; c++) begin lo_lo = 1; xtal = 1; tick(); end
    chk(unlock == 1, "R9", unlock, 1);
    urd = 1; tick(); urd = 0;
    bad = 0;
    for (int c = 0; c < 500; c++) begin lo_lo = 1; xtal = 1; tick(); if (unlock) bad = 1; end
    chk(!bad, "R9", bad, 0);

    // R8 divided faster than reference: drives high, never low
    set_cfg(0, 0, 16'd5);
    for (int c = 0; c < 600; c++) begin lo_lo = 1; xtal = 1; tick(); end
    nolo = 1; sawhi = 0;
    for (int c = 0; c < 1000; c++) begin
      lo_lo = 1; xtal = 1; tick();
      if (pd_oe && !pd_val) nolo = 0;
      if (pd_oe && pd_val)  sawhi = 1;
    end
    chk(nolo, "R8", nolo, 1);
    chk(sawhi, "R8", sawhi, 1);
    chk(unlock == 1, "R9", unlock, 1);

    // R8 divided slower than reference: drives low, never high
    set_cfg(0, 0, 16'd4000);
    for (int c = 0; c < 300; c++) begin lo_lo = 1; xtal = 1; tick(); end
    nohi = 1; sawlo = 0;
    for (int c = 0; c < 3000; c++) begin
      lo_lo = 1; xtal = 1; tick();
      if (pd_oe && pd_val)  nohi = 0;
      if (pd_oe && !pd_val) sawlo = 1;
    end
    chk(nohi, "R8", nohi, 1);
    chk(sawlo, "R8", sawlo, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule